// File: doc/BRIEF.md
# CAN Frame FIFO Byte Packer

This block sits between a parallel CAN frame and a byte-wide FIFO port of a CAN controller. A frame is made of a 29-bit identifier field, an extended flag, a remote flag, a 4-bit length and up to eight data bytes.

On the transmit side, a frame is accepted through a valid/ready handshake. The block then issues its byte image one byte per accepted handshake. The image is a zero tag byte, the identifier bytes in the layout that fits the frame type, a length byte, and only the data bytes that are in use. A one-cycle done pulse marks the end of the frame.

On the receive side, the block collects a fixed 14-byte record from a byte stream and rebuilds the parallel frame. It presents the result with a one-cycle valid strobe. An abort input throws away a record that is only partly collected.

Top module: `can_fifo_packer`

## Requirements
- R1: The first byte issued for every transmit frame is 0x00.
- R2: For a frame with tx_ext=0, the bytes after the tag are id[10:3], then {id[2:0], rtr, 4'b0000}, then the length byte, then the data bytes. Data byte j is taken from tx_data[8j+7:8j], with j=0 sent first. The frame is 4 bytes plus the data count in total.
- R3: For a frame with tx_ext=1, the bytes after the tag are id[28:21], then {id[20:18], 2'b11, id[17:15]}, then id[14:7], then {id[6:0], rtr}, then the length byte, then the data bytes. The frame is 6 bytes plus the data count in total.
- R4: A transmit length above 8 is sent as 8, both in the length byte and in the number of data bytes. A length of 0 sends no data bytes.
- R5: tx_frame_ready is high exactly when no frame is being sent. tx_byte_valid is high exactly while one is being sent. Each cycle with tx_byte_valid and tx_byte_ready high consumes one byte, and tx_byte holds its value while it is stalled.
- R6: tx_done is high for exactly one cycle, the cycle after the last byte of a frame is accepted.
- R7: In a receive record, bit 7 of byte 0 set marks an extended frame. The extended identifier is {b1, b2[7:5], b2[2:0], b3, b4[7:1]}, where bN is record byte N.
- R8: When bit 7 of byte 0 is clear, rx_id is {18'b0, b1, b2[7:5]}.
- R9: rx_rtr is bit 0 of record byte 4. When rx_rtr is set, rx_data is all zero. Otherwise, data byte j is record byte 6+j for j below rx_len and zero above that.
- R10: rx_len is the low nibble of record byte 5, with values above 8 reported as 8. The high nibble of byte 5 has no effect.
- R11: rx_abort discards any partly collected record and produces no frame. A byte offered in the same cycle as rx_abort is dropped, and the next byte starts a new record at byte 0.
- R12: rx_frame_valid pulses for one cycle, in the cycle after the 14th byte of a record is taken. Gaps in rx_byte_valid between bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_frame_valid | input | 1 | Transmit frame offered |
| tx_frame_ready | output | 1 | Transmit frame can be taken |
| tx_id | input | 29 | Identifier; low 11 bits used for standard frames |
| tx_ext | input | 1 | Extended identifier frame |
| tx_rtr | input | 1 | Remote request flag |
| tx_len | input | 4 | Data length, clamped to 8 |
| tx_data | input | 64 | Data bytes, byte j at bits 8j+7:8j |
| tx_byte | output | 8 | Outgoing FIFO byte |
| tx_byte_valid | output | 1 | Outgoing byte present |
| tx_byte_ready | input | 1 | FIFO takes the outgoing byte |
| tx_done | output | 1 | One-cycle end-of-frame pulse |
| rx_byte | input | 8 | Incoming record byte |
| rx_byte_valid | input | 1 | Incoming byte present |
| rx_abort | input | 1 | Discard the record in progress |
| rx_frame_valid | output | 1 | Rebuilt frame strobe |
| rx_id | output | 29 | Rebuilt identifier |
| rx_ext | output | 1 | Rebuilt extended flag |
| rx_rtr | output | 1 | Rebuilt remote flag |
| rx_len | output | 4 | Rebuilt length, at most 8 |
| rx_data | output | 64 | Rebuilt data, byte j at bits 8j+7:8j |

## Verification
The hardest case to reach from the ports is a stall on the transmit side at every byte position, including the last one, just before the done pulse. The bench reaches it by driving tx_byte_ready from a random source that is often low, and by sending frames of each length and both identifier types back to back. On the receive side, the awkward case is an abort that lands on the same cycle as a valid byte and is followed at once by a full record. The bench sends aborted partial records of several lengths, each followed by a complete record with gaps between bytes.

// File: rtl/can_pk_pkg.sv
package can_pk_pkg;

    localparam int unsigned ID_W     = 29;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned DATA_MAX = 8;
    localparam int unsigned LEN_W    = 4;
    localparam int unsigned STD_HDR  = 4;
    localparam int unsigned EXT_HDR  = 6;
    localparam int unsigned REC_LEN  = EXT_HDR + DATA_MAX;
    localparam int unsigned IDX_W    = $clog2(REC_LEN + 1);
    localparam int unsigned CNT_W    = $clog2(REC_LEN);
    localparam int unsigned DIDX_W   = $clog2(DATA_MAX);

    typedef struct packed {
        logic [ID_W-1:0]                    id;
        logic                               ext;
        logic                               rtr;
        logic [LEN_W-1:0]                   len;
        logic [DATA_MAX-1:0][BYTE_W-1:0]    data;
    } can_frame_t;

    typedef logic [REC_LEN-1:0][BYTE_W-1:0] can_rec_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (l > LEN_W'(DATA_MAX)) ? LEN_W'(DATA_MAX) : l;
    endfunction

    function automatic logic [IDX_W-1:0] tx_total(input logic ext, input logic [LEN_W-1:0] l);
        logic [IDX_W-1:0] hdr;
        hdr = ext ? IDX_W'(EXT_HDR) : IDX_W'(STD_HDR);
        return hdr + IDX_W'(clamp_len(l));
    endfunction

    // Byte k of the transmit image; f.len is already clamped by the caller.
    function automatic logic [BYTE_W-1:0] tx_byte_at(input can_frame_t f, input logic [IDX_W-1:0] k);
        logic [IDX_W-1:0] hdr;
        logic [IDX_W-1:0] d;
        logic [BYTE_W-1:0] b;
        hdr = f.ext ? IDX_W'(EXT_HDR) : IDX_W'(STD_HDR);
        d   = k - hdr;
        b   = '0;
        if (k == '0) begin
            b = '0;
        end else if (k == hdr - IDX_W'(1)) begin
            b = BYTE_W'(f.len);
        end else if (k >= hdr) begin
            b = f.data[d[DIDX_W-1:0]];
        end else if (f.ext) begin
            case (k)
                IDX_W'(1): b = f.id[28:21];
                IDX_W'(2): b = {f.id[20:18], 2'b11, f.id[17:15]};
                IDX_W'(3): b = f.id[14:7];
                default:   b = {f.id[6:0], f.rtr};
            endcase
        end else begin
            if (k == IDX_W'(1)) b = f.id[10:3];
            else                b = {f.id[2:0], f.rtr, 4'b0000};
        end
        return b;
    endfunction

    function automatic can_frame_t rx_decode(input can_rec_t r);
        can_frame_t f;
        f.ext = r[0][7];
        f.rtr = r[4][0];
        if (f.ext) f.id = {r[1], r[2][7:5], r[2][2:0], r[3], r[4][7:1]};
        else       f.id = {18'b0, r[1], r[2][7:5]};
        f.len = clamp_len(r[5][LEN_W-1:0]);
        for (int j = 0; j < DATA_MAX; j++) begin
            f.data[j] = (!f.rtr && (j < int'(f.len))) ? r[EXT_HDR + j] : '0;
        end
        return f;
    endfunction

endpackage

// File: rtl/can_tx_serializer.sv
module can_tx_serializer
    import can_pk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 frm_valid,
    output logic                 frm_ready,
    input  can_frame_t           frm,
    output logic [BYTE_W-1:0]    byte_o,
    output logic                 byte_valid,
    input  logic                 byte_ready,
    output logic                 done
);

    logic             busy;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] total;
    can_frame_t       cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            total <= '0;
            cur   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (frm_valid) begin
                    cur     <= frm;
                    cur.len <= clamp_len(frm.len);
                    total   <= tx_total(frm.ext, frm.len);
                    idx     <= '0;
                    busy    <= 1'b1;
                end
            end else if (byte_ready) begin
                if (idx == total - IDX_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    assign frm_ready  = !busy;
    assign byte_valid = busy;
    assign byte_o     = tx_byte_at(cur, idx);

    assert_tag_first_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_valid) |-> (byte_o == 8'h00));

    assert_hold_stall_R5: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_o)));

    assert_excl_ready_R5: assert property (@(posedge clk) disable iff (rst)
        !(frm_ready && byte_valid));

    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(byte_valid && byte_ready) && !byte_valid));

endmodule

// File: rtl/can_rx_assembler.sv
module can_rx_assembler
    import can_pk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BYTE_W-1:0]    byte_i,
    input  logic                 byte_valid,
    input  logic                 abort,
    output logic                 frame_valid,
    output can_frame_t           frame
);

    logic [CNT_W-1:0] cnt;
    can_rec_t         rec;
    can_rec_t         merged;

    always_comb begin
        merged      = rec;
        merged[cnt] = byte_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt         <= '0;
            rec         <= '0;
            frame       <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (abort) begin
                cnt <= '0;
            end else if (byte_valid) begin
                rec <= merged;
                if (cnt == CNT_W'(REC_LEN - 1)) begin
                    cnt         <= '0;
                    frame       <= rx_decode(merged);
                    frame_valid <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assert_abort_drops_R11: assert property (@(posedge clk) disable iff (rst)
        abort |=> !frame_valid);

    assert_rtr_no_data_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && frame.rtr) |-> (frame.data == '0));

    assert_len_cap_R10: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> (frame.len <= LEN_W'(DATA_MAX)));

    assert_strobe_after_byte_R12: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> $past(byte_valid && !abort));

endmodule

// File: rtl/can_fifo_packer.sv
module can_fifo_packer
    import can_pk_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         tx_frame_valid,
    output logic                         tx_frame_ready,
    input  logic [ID_W-1:0]              tx_id,
    input  logic                         tx_ext,
    input  logic                         tx_rtr,
    input  logic [LEN_W-1:0]             tx_len,
    input  logic [DATA_MAX*BYTE_W-1:0]   tx_data,
    output logic [BYTE_W-1:0]            tx_byte,
    output logic                         tx_byte_valid,
    input  logic                         tx_byte_ready,
    output logic                         tx_done,
    input  logic [BYTE_W-1:0]            rx_byte,
    input  logic                         rx_byte_valid,
    input  logic                         rx_abort,
    output logic                         rx_frame_valid,
    output logic [ID_W-1:0]              rx_id,
    output logic                         rx_ext,
    output logic                         rx_rtr,
    output logic [LEN_W-1:0]             rx_len,
    output logic [DATA_MAX*BYTE_W-1:0]   rx_data
);

    can_frame_t tx_frm;
    can_frame_t rx_frm;

    assign tx_frm.id   = tx_id;
    assign tx_frm.ext  = tx_ext;
    assign tx_frm.rtr  = tx_rtr;
    assign tx_frm.len  = tx_len;
    assign tx_frm.data = tx_data;

    can_tx_serializer u_tx (
        .clk        (clk),
        .rst        (rst),
        .frm_valid  (tx_frame_valid),
        .frm_ready  (tx_frame_ready),
        .frm        (tx_frm),
        .byte_o     (tx_byte),
        .byte_valid (tx_byte_valid),
        .byte_ready (tx_byte_ready),
        .done       (tx_done)
    );

    can_rx_assembler u_rx (
        .clk         (clk),
        .rst         (rst),
        .byte_i      (rx_byte),
        .byte_valid  (rx_byte_valid),
        .abort       (rx_abort),
        .frame_valid (rx_frame_valid),
        .frame       (rx_frm)
    );

    assign rx_id   = rx_frm.id;
    assign rx_ext  = rx_frm.ext;
    assign rx_rtr  = rx_frm.rtr;
    assign rx_len  = rx_frm.len;
    assign rx_data = rx_frm.data;

endmodule

// File: tb/sim_can_fifo_packer.sv
module sim_can_fifo_packer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_frame_valid = 1'b0;
    logic        tx_frame_ready;
    logic [28:0] tx_id = '0;
    logic        tx_ext = 1'b0;
    logic        tx_rtr = 1'b0;
    logic [3:0]  tx_len = '0;
    logic [63:0] tx_data = '0;
    logic [7:0]  tx_byte;
    logic        tx_byte_valid;
    logic        tx_byte_ready = 1'b0;
    logic        tx_done;
    logic [7:0]  rx_byte = '0;
    logic        rx_byte_valid = 1'b0;
    logic        rx_abort = 1'b0;
    logic        rx_frame_valid;
    logic [28:0] rx_id;
    logic        rx_ext;
    logic        rx_rtr;
    logic [3:0]  rx_len;
    logic [63:0] rx_data;

    always #4 clk = ~clk;

    can_fifo_packer u0 (.*);

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model state
    logic [7:0] q_tx[$];
    string      q_tag[$];
    bit         exp_done = 0;
    logic [7:0] q_rx[$];
    bit         exp_rxv = 0;
    logic [28:0] e_id;
    bit          e_ext, e_rtr;
    int          e_len;
    logic [63:0] e_data;
    bit          model_on = 0;

    task automatic model_push_tx();
        int n;
        int id;
        n  = (tx_len > 8) ? 8 : int'(tx_len);
        id = int'(tx_id);
        q_tx.push_back(8'h00); q_tag.push_back("R1 tag");
        if (tx_ext) begin
            q_tx.push_back(8'((id >> 21) & 255));                                    q_tag.push_back("R3 id0");
            q_tx.push_back(8'(((id >> 13) & 8'he0) | 8'h18 | ((id >> 15) & 7)));     q_tag.push_back("R3 id1");
            q_tx.push_back(8'((id >> 7) & 255));                                     q_tag.push_back("R3 id2");
            q_tx.push_back(8'(((id << 1) & 255) | int'(tx_rtr)));                    q_tag.push_back("R3 id3");
        end else begin
            q_tx.push_back(8'((id >> 3) & 255));                                     q_tag.push_back("R2 id0");
            q_tx.push_back(8'(((id << 5) & 8'he0) | (int'(tx_rtr) << 4)));           q_tag.push_back("R2 id1");
        end
        q_tx.push_back(8'(n)); q_tag.push_back("R4 dlc");
        for (int j = 0; j < n; j++) begin
            q_tx.push_back(tx_data[8*j +: 8]);
            q_tag.push_back(tx_ext ? "R3 data" : "R2 data");
        end
    endtask

    task automatic model_decode_rx();
        int b1, b2, b3, b4;
        b1 = int'(q_rx[1]); b2 = int'(q_rx[2]); b3 = int'(q_rx[3]); b4 = int'(q_rx[4]);
        e_ext = q_rx[0][7];
        if (e_ext) e_id = 29'((b1 << 21) | ((b2 >> 5) << 18) | ((b2 & 7) << 15) | (b3 << 7) | (b4 >> 1));
        else       e_id = 29'((b1 << 3) | (b2 >> 5));
        e_rtr = q_rx[4][0];
        e_len = int'(q_rx[5] & 8'h0f);
        if (e_len > 8) e_len = 8;
        e_data = '0;
        if (!e_rtr)
            for (int j = 0; j < e_len; j++) e_data[8*j +: 8] = q_rx[6 + j];
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk(tx_frame_ready == (q_tx.size() == 0), "R5 frame_ready", 64'(tx_frame_ready), 64'(q_tx.size() == 0));
            chk(tx_byte_valid == (q_tx.size() != 0), "R5 byte_valid", 64'(tx_byte_valid), 64'(q_tx.size() != 0));
            if (q_tx.size() != 0 && tx_byte_valid)
                chk(tx_byte == q_tx[0], q_tag[0], 64'(tx_byte), 64'(q_tx[0]));
            chk(tx_done == exp_done, "R6 done", 64'(tx_done), 64'(exp_done));
            chk(rx_frame_valid == exp_rxv, "R11 R12 rx_frame_valid", 64'(rx_frame_valid), 64'(exp_rxv));
            if (exp_rxv && rx_frame_valid) begin
                chk(rx_ext == e_ext, "R7 ext", 64'(rx_ext), 64'(e_ext));
                chk(rx_id == e_id, e_ext ? "R7 ext id" : "R8 std id", 64'(rx_id), 64'(e_id));
                chk(rx_rtr == e_rtr, "R9 rtr", 64'(rx_rtr), 64'(e_rtr));
                chk(int'(rx_len) == e_len, "R10 len", 64'(rx_len), 64'(e_len));
                chk(rx_data == e_data, "R9 data", rx_data, e_data);
            end
            // prediction for the next cycle
            exp_done = 0;
            if (tx_byte_valid && tx_byte_ready && q_tx.size() != 0) begin
                void'(q_tx.pop_front());
                void'(q_tag.pop_front());
                if (q_tx.size() == 0) exp_done = 1;
            end
            if (tx_frame_valid && tx_frame_ready) model_push_tx();
            exp_rxv = 0;
            if (rx_abort) begin
                q_rx.delete();
            end else if (rx_byte_valid) begin
                q_rx.push_back(rx_byte);
                if (q_rx.size() == 14) begin
                    model_decode_rx();
                    q_rx.delete();
                    exp_rxv = 1;
                end
            end
        end
    end

    int ready_mode = 0; // 0 random, 1 always, 2 mostly low

    initial begin
        forever begin
            @(posedge clk); #1;
            case (ready_mode)
                1:       tx_byte_ready = 1'b1;
                2:       tx_byte_ready = ($urandom % 5) == 0;
                default: tx_byte_ready = ($urandom % 2) == 0;
            endcase
        end
    end

    task automatic send_tx(input logic [28:0] id, input bit ext, input bit rtr, input logic [3:0] len, input logic [63:0] data);
        bit acc;
        @(posedge clk); #1;
        tx_id = id; tx_ext = ext; tx_rtr = rtr; tx_len = len; tx_data = data;
        tx_frame_valid = 1'b1;
        do begin
            @(negedge clk); acc = tx_frame_ready;
            @(posedge clk); #1;
        end while (!acc);
        tx_frame_valid = 1'b0;
        tx_data = ~data;
    endtask

    task automatic send_rec(input logic [7:0] r [14], input int abort_at, input bit gaps);
        for (int i = 0; i < 14; i++) begin
            @(posedge clk); #1;
            rx_abort = 1'b0;
            if (gaps && ($urandom % 3) == 0) begin
                rx_byte_valid = 1'b0;
                @(posedge clk); #1;
            end
            rx_byte = r[i];
            rx_byte_valid = 1'b1;
            if (i == abort_at) begin
                rx_abort = 1'b1;
                break;
            end
        end
        @(posedge clk); #1;
        rx_byte_valid = 1'b0;
        rx_abort = 1'b0;
    endtask

    task automatic mk_rec(output logic [7:0] r [14], input bit ext, input logic [28:0] id,
                          input bit rtr, input logic [7:0] dlc, input logic [63:0] data);
        int v;
        v = int'(id);
        r[0] = ext ? 8'h80 : 8'h00;
        if (ext) begin
            r[1] = 8'(v >> 21);
            r[2] = 8'(((v >> 13) & 8'he0) | 8'h18 | ((v >> 15) & 7));
            r[3] = 8'(v >> 7);
            r[4] = 8'(((v << 1) & 255) | int'(rtr));
        end else begin
            r[1] = 8'(v >> 3);
            r[2] = 8'((v << 5) & 8'he0);
            r[3] = 8'h5a;
            r[4] = {7'h33, rtr};
        end
        r[5] = dlc;
        for (int j = 0; j < 8; j++) r[6 + j] = data[8*j +: 8];
    endtask

    task automatic tx_all();
        ready_mode = 1;
        send_tx(29'h5a5, 0, 0, 4'd0, 64'h0);
        send_tx(29'h7ff, 0, 0, 4'd8, 64'h8877665544332211);
        ready_mode = 0;
        send_tx(29'h1abcdef1, 1, 1, 4'd3, 64'hdead_beef_cafe_f00d);
        send_tx(29'h0000123, 0, 1, 4'd15, 64'h0102030405060708);   // R4 clamp
        ready_mode = 2;
        send_tx(29'h1fffffff, 1, 0, 4'd9, 64'hfedcba9876543210);   // R4 clamp
        send_tx(29'h0, 1, 0, 4'd0, 64'h0);
        for (int i = 0; i < 12; i++) begin
            ready_mode = i % 3;
            send_tx(29'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), {$urandom, $urandom});
        end
        ready_mode = 1;
        repeat (20) @(posedge clk);
    endtask

    task automatic rx_all();
        logic [7:0] r [14];
        mk_rec(r, 0, 29'h3c5, 0, 8'h04, 64'h8877665544332211);
        send_rec(r, -1, 0);
        mk_rec(r, 1, 29'h12345678, 0, 8'hf8, 64'h0102030405060708);  // R10 high nibble ignored
        send_rec(r, -1, 1);
        mk_rec(r, 1, 29'h0abcdef0, 1, 8'h05, 64'hffffffffffffffff);  // R9 rtr
        send_rec(r, -1, 0);
        mk_rec(r, 0, 29'h001, 0, 8'h0e, 64'h1122334455667788);       // R10 clamp
        send_rec(r, -1, 1);
        mk_rec(r, 1, 29'h1fffffff, 0, 8'h08, 64'haaaaaaaaaaaaaaaa);
        send_rec(r, 6, 0);                                           // R11 abort partial
        send_rec(r, 13, 0);                                          // R11 abort on last byte
        send_rec(r, 0, 1);                                           // R11 abort on first byte
        mk_rec(r, 0, 29'h7ff, 1, 8'h02, 64'h55);
        send_rec(r, -1, 1);
        for (int i = 0; i < 10; i++) begin
            mk_rec(r, 1'($urandom), 29'($urandom), 1'($urandom), 8'($urandom), {$urandom, $urandom});
            send_rec(r, (i % 3 == 0) ? int'($urandom % 14) : -1, 1'($urandom));
        end
        repeat (5) @(posedge clk);
    endtask

    bit wd = 0;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(tx_frame_ready == 1'b1, "R5 reset ready", 64'(tx_frame_ready), 64'd1);
        chk(tx_byte_valid == 1'b0, "R5 reset byte_valid", 64'(tx_byte_valid), 64'd0);
        chk(tx_done == 1'b0, "R6 reset done", 64'(tx_done), 64'd0);
        chk(rx_frame_valid == 1'b0, "R12 reset rx_frame_valid", 64'(rx_frame_valid), 64'd0);
        model_on = 1;
        fork
            begin
                fork
                    tx_all();
                    rx_all();
                join
            end
            begin
                repeat (100000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
        end
        chk(q_tx.size() == 0, "R5 tx drained", 64'(q_tx.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule